// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block converts per-phase PWM decisions into high-side and low-side gate enables for a multi-phase synchronous buck stage. A master oscillator counter, built from the system clock, hands out one-cycle phase clock pulses in rotation. Each phase therefore runs at the master rate divided by the phase count, and with the default of two phases the phases sit 180 degrees apart.

Modulation is leading-edge. A phase clock pulse ends the high-side conduction. The high side turns on again once the error-versus-ramp comparator flag reports a trip. Changeover between the two switches waits on sensed node flags and not on fixed delays. The low side is enabled only once the switch node reads low. The high side is enabled only once the low-side gate voltage reads low.

Each period the low side stays on for a guaranteed minimum number of clocks. A reverse-current flag cuts the low side off early, so the stage emulates a diode. A forced-safe input, used by the protection logic, parks the phase with the low side on. Comparators, ramps and drivers live outside the block and appear here only as input flags.

Top module: `dt_gate_seq`

## Requirements
- R1: The high-side enable rises only after a comparator trip, and only once the low-side minimum has elapsed. It falls in the cycle after the phase clock pulse is seen.
- R2: Once the high side is off, the low-side enable stays low while `node_low_i` is 0. It rises in the cycle after `node_low_i` is sampled as 1.
- R3: Once the low side is off by a trip, the high-side enable stays low while `lgate_low_i` is 0. It rises in the cycle after `lgate_low_i` is sampled as 1.
- R4: Each low-side conduction lasts at least LS_MIN clocks, and a trip arriving earlier is ignored. LS_MIN = max(MIN_LS_CNT, (NUM_PH*OSC_CNT)/10), which is 33 by default.
- R5: At low switching rates the 10 % floor dominates. With OSC_CNT=100 and MIN_LS_CNT=4, the low side lasts exactly 20 clocks when the trip is held. The high side then lasts 178 clocks of the 200-clock period.
- R6: If `rev_cur_i` is sampled as 1 while the low side is on, both enables go low in the next cycle. They stay low, with trips ignored, until the next phase clock pulse.
- R7: `ph_edge_o[k]` is a one-cycle pulse every NUM_PH*OSC_CNT clocks. Phase k+1 pulses OSC_CNT clocks after phase k, so the spacing is 50 clocks by default.
- R8: While `force_safe_i` is 1, the high side goes low in the next cycle. The low side comes on subject to R2 and stays on whatever the trip, reverse-current and phase clock inputs do.
- R9: The two enables of a phase are never high together. The high side never rises in the cycle right after the low side was high.
- R10: Reset clears both enables and all phase pulses. A phase stays fully off until its first phase clock pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| force_safe_i | input | 1 | Protection override: high side off, low side on |
| trip_i | input | NUM_PH | Error signal has met the ramp, per phase |
| node_low_i | input | NUM_PH | Switch node below about 2 V, per phase |
| lgate_low_i | input | NUM_PH | Low-side gate below about 2 V, per phase |
| rev_cur_i | input | NUM_PH | Reverse inductor current seen during low-side on, per phase |
| ph_edge_o | output | NUM_PH | Phase clock pulse, for ramp alignment |
| hs_en_o | output | NUM_PH | High-side gate enable |
| ls_en_o | output | NUM_PH | Low-side gate enable |

## Verification
The assertions assume that the flag inputs are synchronous to `clk_i` and only change between edges. They also take the node and gate-voltage flags at face value, with no check that they follow the enables physically. The stimulus changes every flag at the falling clock edge and holds it for whole cycles. The node-low and gate-low flags are held low for several cycles to expose the waits, then raised. Reverse current and forced-safe are applied from the states in which they matter: low side on, and high side on, respectively.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  typedef enum logic [2:0] {
    ST_OFF,        // after reset, waits for first phase pulse
    ST_WAIT_NODE,  // high side off, waiting for node low
    ST_LS_ON,
    ST_WAIT_GATE,  // low side off, waiting for its gate low
    ST_HS_ON,
    ST_DIODE       // both off for rest of period
  } seq_st_e;
endpackage

// File: rtl/dtg_phase_timer.sv
module dtg_phase_timer #(
  parameter int NUM_PH  = 2,
  parameter int OSC_CNT = 50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [NUM_PH-1:0] edge_o
);
  localparam int CW    = (OSC_CNT > 1) ? $clog2(OSC_CNT) : 1;
  localparam int SEL_W = (NUM_PH > 1) ? $clog2(NUM_PH) : 1;

  logic [CW-1:0]    cnt_q;
  logic [SEL_W-1:0] sel_q;
  logic [NUM_PH-1:0] edge_q;
  logic             wrap;

  assign wrap = (cnt_q == CW'(OSC_CNT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sel_q <= '0;
    end else if (wrap) begin
      cnt_q <= '0;
      sel_q <= (sel_q == SEL_W'(NUM_PH - 1)) ? '0 : sel_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  for (genvar k = 0; k < NUM_PH; k++) begin : g_edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) edge_q[k] <= 1'b0;
      else         edge_q[k] <= wrap && (sel_q == SEL_W'(k));
    end
  end

  assign edge_o = edge_q;

  a_r7_one_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(edge_q));
  a_r7_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|edge_q) |=> !(|edge_q));
endmodule

// File: rtl/dtg_ls_timer.sv
module dtg_ls_timer #(
  parameter int LS_MIN = 33
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic done_o
);
  localparam int W = $clog2(LS_MIN + 1);

  logic [W-1:0] cnt_q;

  assign done_o = (cnt_q >= W'(LS_MIN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clear_i)           cnt_q <= '0;
    else if (run_i && !done_o)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dtg_phase_seq.sv
module dtg_phase_seq
  import dtg_pkg::*;
#(
  parameter int LS_MIN = 33
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  input  logic force_i,
  input  logic trip_i,
  input  logic node_low_i,
  input  logic lgate_low_i,
  input  logic rev_i,
  output logic hs_o,
  output logic ls_o
);
  seq_st_e state_q, state_d;
  logic    hs_q, ls_q;
  logic    min_done, tmr_clear;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:       if (force_i) state_d = ST_LS_ON;
                    else if (edge_i) state_d = ST_WAIT_NODE;
      ST_WAIT_NODE: if (node_low_i) state_d = ST_LS_ON;
      ST_LS_ON:     if (!force_i && !edge_i) begin
                      if (rev_i)                    state_d = ST_DIODE;
                      else if (trip_i && min_done) state_d = ST_WAIT_GATE;
                    end
      ST_WAIT_GATE: if (force_i || edge_i) state_d = ST_LS_ON;
                    else if (lgate_low_i) state_d = ST_HS_ON;
      ST_HS_ON:     if (force_i || edge_i) state_d = ST_WAIT_NODE;
      ST_DIODE:     if (force_i) state_d = ST_LS_ON;
                    else if (edge_i) state_d = ST_WAIT_NODE;
      default:      state_d = ST_OFF;
    endcase
  end

  // new conduction or new period restarts the minimum window
  assign tmr_clear = (state_d == ST_LS_ON) && ((state_q != ST_LS_ON) || edge_i);

  dtg_ls_timer #(.LS_MIN(LS_MIN)) i_ls_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (tmr_clear),
    .run_i   (state_q == ST_LS_ON),
    .done_o  (min_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      hs_q    <= 1'b0;
      ls_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      hs_q    <= (state_d == ST_HS_ON);
      ls_q    <= (state_d == ST_LS_ON);
    end
  end

  assign hs_o = hs_q;
  assign ls_o = ls_q;

  a_r2_wait_node: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_NODE && !node_low_i) |=> !ls_q);
  a_r3_wait_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_GATE && !lgate_low_i && !force_i && !edge_i) |=> !hs_q);
  a_r4_min_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ls_q) && !$past(rev_i)) |-> $past(min_done));
  a_r6_rev_cut: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LS_ON && rev_i && !force_i && !edge_i) |=> (!ls_q && !hs_q));
  a_r8_force_hs_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |=> !hs_q);
  a_r9_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_q && ls_q));
  a_r9_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_q) |-> $past(!ls_q));
endmodule

// File: rtl/dt_gate_seq.sv
module dt_gate_seq #(
  parameter int NUM_PH     = 2,
  parameter int OSC_CNT    = 50,
  parameter int MIN_LS_CNT = 33
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              force_safe_i,
  input  logic [NUM_PH-1:0] trip_i,
  input  logic [NUM_PH-1:0] node_low_i,
  input  logic [NUM_PH-1:0] lgate_low_i,
  input  logic [NUM_PH-1:0] rev_cur_i,
  output logic [NUM_PH-1:0] ph_edge_o,
  output logic [NUM_PH-1:0] hs_en_o,
  output logic [NUM_PH-1:0] ls_en_o
);
  localparam int PH_PERIOD = NUM_PH * OSC_CNT;
  localparam int DUTY_FLR  = PH_PERIOD / 10;
  localparam int LS_RAW    = (MIN_LS_CNT > DUTY_FLR) ? MIN_LS_CNT : DUTY_FLR;
  localparam int LS_MIN    = (LS_RAW > 0) ? LS_RAW : 1;

  logic [NUM_PH-1:0] edge_w;

  dtg_phase_timer #(.NUM_PH(NUM_PH), .OSC_CNT(OSC_CNT)) i_phase_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .edge_o (edge_w)
  );

  assign ph_edge_o = edge_w;

  for (genvar p = 0; p < NUM_PH; p++) begin : g_phase
    dtg_phase_seq #(.LS_MIN(LS_MIN)) i_seq (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .edge_i      (edge_w[p]),
      .force_i     (force_safe_i),
      .trip_i      (trip_i[p]),
      .node_low_i  (node_low_i[p]),
      .lgate_low_i (lgate_low_i[p]),
      .rev_i       (rev_cur_i[p]),
      .hs_o        (hs_en_o[p]),
      .ls_o        (ls_en_o[p])
    );
  end
endmodule

// File: tb/test_dt_gate_seq.sv
module test_dt_gate_seq;
  localparam int NPH    = 2;
  localparam int MP     = 50;
  localparam int LF_MP  = 100;
  localparam int LF_LS  = 20;
  localparam int LF_HS  = 178;

  logic clk, rst_ni;
  logic force_a, force_b;
  logic [NPH-1:0] trip_a, node_a, gate_a, rev_a;
  logic [NPH-1:0] trip_b, node_b, gate_b, rev_b;
  logic [NPH-1:0] edge_a, hs_a, ls_a, edge_b, hs_b, ls_b;

  int n_chk = 0, n_err = 0, mon_err = 0;
  bit done = 0;

  dt_gate_seq #(.NUM_PH(NPH), .OSC_CNT(MP), .MIN_LS_CNT(33)) i_dt_gate_seq (
    .clk_i(clk), .rst_ni(rst_ni), .force_safe_i(force_a),
    .trip_i(trip_a), .node_low_i(node_a), .lgate_low_i(gate_a), .rev_cur_i(rev_a),
    .ph_edge_o(edge_a), .hs_en_o(hs_a), .ls_en_o(ls_a));

  dt_gate_seq #(.NUM_PH(NPH), .OSC_CNT(LF_MP), .MIN_LS_CNT(4)) i_dt_gate_seq_lf (
    .clk_i(clk), .rst_ni(rst_ni), .force_safe_i(force_b),
    .trip_i(trip_b), .node_low_i(node_b), .lgate_low_i(gate_b), .rev_cur_i(rev_b),
    .ph_edge_o(edge_b), .hs_en_o(hs_b), .ls_en_o(ls_b));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {trip,node,gate,rev}, hold cycles, expected {hs,ls}
  localparam logic [13:0] VEC [14] = '{
    {4'b0000, 8'd1,  2'b00},  // R10/R2 edge seen, node high
    {4'b0000, 8'd3,  2'b00},  // R2 wait for node low
    {4'b0100, 8'd1,  2'b01},  // R2 low side on
    {4'b1100, 8'd32, 2'b01},  // R4 early trip ignored
    {4'b1100, 8'd1,  2'b00},  // R4 released after 33
    {4'b0000, 8'd2,  2'b00},  // R3 wait for gate low
    {4'b0010, 8'd1,  2'b10},  // R3 high side on
    {4'b0010, 8'd59, 2'b10},  // R1 held until phase pulse
    {4'b0000, 8'd1,  2'b00},  // R1 off at pulse
    {4'b0100, 8'd1,  2'b01},  // R2
    {4'b0101, 8'd1,  2'b00},  // R6 reverse current cut
    {4'b1110, 8'd97, 2'b00},  // R6 trip ignored rest of period
    {4'b0100, 8'd1,  2'b00},  // R6 pulse ends diode period
    {4'b0100, 8'd5,  2'b01}   // R2 next conduction
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  logic [NPH-1:0] hs_a_p, ls_a_p, hs_b_p, ls_b_p;
  always @(negedge clk) begin
    if (rst_ni) begin
      for (int p = 0; p < NPH; p++) begin
        if (hs_a[p] && ls_a[p]) mon_err++;
        if (hs_b[p] && ls_b[p]) mon_err++;
        if (hs_a[p] && !hs_a_p[p] && ls_a_p[p]) mon_err++;
        if (hs_b[p] && !hs_b_p[p] && ls_b_p[p]) mon_err++;
      end
    end
    hs_a_p <= hs_a; ls_a_p <= ls_a; hs_b_p <= hs_b; ls_b_p <= ls_b;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int n, bad;
    rst_ni = 1'b0; force_a = 0; force_b = 0;
    trip_a = 2'b10; node_a = 2'b10; gate_a = 2'b10; rev_a = '0;
    trip_b = 2'b11; node_b = 2'b11; gate_b = 2'b11; rev_b = '0;
    repeat (3) step();
    check("R10 reset hs", int'(hs_a), 0);
    check("R10 reset ls", int'(ls_a), 0);
    check("R10 reset edge", int'(edge_a), 0);
    rst_ni = 1'b1;
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      step();
      if (hs_a[0] || ls_a[0]) bad++;
    end
    check("R10 off before first pulse", bad, 0);

    // R7 pulse spacing
    n = 0;
    while (!edge_a[0] && n < 500) begin step(); n++; end
    n = 0;
    do begin step(); n++; if (n == 1) check("R7 one-cycle pulse", int'(edge_a[0]), 0); end
    while (!edge_a[1] && n < 500);
    check("R7 phase offset", n, MP);
    n = 0;
    do begin step(); n++; end while (!edge_a[0] && n < 500);
    check("R7 phase period gap", n, MP);

    // vector walk, starting at a visible phase-0 pulse
    for (int i = 0; i < 14; i++) begin
      {trip_a[0], node_a[0], gate_a[0], rev_a[0]} = VEC[i][13:10];
      for (int r = 0; r < int'(VEC[i][9:2]); r++) begin
        step();
        check($sformatf("vector %0d hs/ls", i), int'({hs_a[0], ls_a[0]}), int'(VEC[i][1:0]));
      end
    end

    // R8 forced-safe from high-side on
    trip_a[0] = 1; node_a[0] = 1; gate_a[0] = 1;
    n = 0;
    while (!hs_a[0] && n < 300) begin step(); n++; end
    check("R1 high side reached", int'(hs_a[0]), 1);
    force_a = 1; node_a[0] = 0;
    step();
    check("R8 forced high side off", int'({hs_a[0], ls_a[0]}), 0);
    step(); step();
    check("R8 R2 forced waits for node", int'({hs_a[0], ls_a[0]}), 0);
    node_a[0] = 1;
    step();
    check("R8 forced low side on", int'({hs_a[0], ls_a[0]}), 1);
    rev_a[0] = 1; trip_a[0] = 1;
    bad = 0;
    for (int i = 0; i < 150; i++) begin
      step();
      if (!ls_a[0] || hs_a[0]) bad++;
    end
    check("R8 forced holds low side", bad, 0);
    force_a = 0; rev_a[0] = 0; trip_a[0] = 0;
    step();
    check("R8 release keeps low side", int'({hs_a[0], ls_a[0]}), 1);

    // R5 low-frequency duty floor
    n = 0;
    while (!(ls_b[0] && !ls_b_p[0]) && n < 1000) begin step(); n++; end
    n = 0;
    while (ls_b[0] && n < 1000) begin step(); n++; end
    check("R5 low side floor width", n, LF_LS);
    while (!hs_b[0] && n < 2000) begin step(); n++; end
    n = 0;
    while (hs_b[0] && n < 1000) begin step(); n++; end
    check("R5 R1 high side width", n, LF_HS);

    check("R9 exclusion and gap monitor", mon_err, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule